// File: doc/BRIEF.md
# Ring-Buffer Line Fetcher

This block streams audio sample data from a circular buffer in system memory into a small local FIFO. The FIFO is drained by a downstream serializer. Software supplies three things: the byte address of the first line, the byte address of the last line (the last line is part of the buffer), and two FIFO fields. Those fields are the usable FIFO depth and the refill threshold, both counted in 64-bit lines and both written as the count minus one.

The engine works through a simple request/response read port, one line per request. Once the line at the finish address has been fetched, the read pointer returns to the start address. A rising edge on the load control puts the pointer back on the start address, so playback restarts at the top of the buffer.

The block continuously reports how far the pointer has moved from the start, so software can track progress through the ring. Clearing the channel enable stops new fetches and empties the FIFO.

Top module: `ringLineFetcher`

## Requirements
- R1: While reset is asserted and afterwards until the channel is enabled, the FIFO level is 0 and no request is raised. Reset sets the read pointer to address 0.
- R2: `memReqAddr` always shows the current read pointer. Each request accepted (`memReqValid` and `memReqReady` high together) moves the pointer forward by 8 bytes, one 64-bit line, in the next cycle.
- R3: Accepting a request whose address equals `finishAddr` sets the pointer to `startAddr` instead of advancing it, so the finish line is the last line fetched before the wrap.
- R4: `memReqValid` is high exactly when all of these hold: the channel is enabled, no request is outstanding, the FIFO level is at most `threshM1`+1, and the FIFO level is at most `depthM1` (that is, the level is below the depth of `depthM1`+1 lines).
- R5: At most one request is outstanding. A request becomes outstanding when accepted and stops being outstanding when `memRspValid` arrives. A `memRspValid` that arrives while nothing is outstanding changes nothing.
- R6: The pointer is loaded from `startAddr` only in a cycle where `loadCtl` is 1 after being 0 in the previous cycle. The previous value counts as 0 after reset. Keeping `loadCtl` high has no further effect. When a load edge and a request acceptance fall in the same cycle, the request carries the old address and the load wins the pointer update.
- R7: `position` equals the read pointer minus `startAddr`, modulo 2^32.
- R8: While `chanEn` is 0, no request is raised and the FIFO level is 0 from the next cycle on. A response that arrives while the channel is disabled is discarded but still ends the outstanding request.
- R9: `popData` shows the oldest FIFO line, and lines leave in arrival order. A `popReq` while the FIFO is empty is ignored.
- R10: A taken response adds one line and a pop with data removes one. When both happen in the same cycle, the level does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanEn | input | 1 | Channel enable; when low, fetching stops and the FIFO is flushed |
| loadCtl | input | 1 | Load control; a rising edge reloads the pointer from the start address |
| startAddr | input | 32 | Byte address of the first buffer line |
| finishAddr | input | 32 | Byte address of the last buffer line (inclusive) |
| depthM1 | input | 4 | Usable FIFO depth in lines, minus one |
| threshM1 | input | 4 | Refill threshold in lines, minus one |
| memReqValid | output | 1 | Read request valid |
| memReqAddr | output | 32 | Read request address (current pointer) |
| memReqReady | input | 1 | Memory accepts the request |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | 64 | Returned 64-bit line |
| popReq | input | 1 | Serializer takes the head line |
| popData | output | 64 | Oldest line in the FIFO |
| fifoLevel | output | 5 | Lines held in the FIFO |
| position | output | 32 | Pointer offset from the start address |

## Verification
The case that needs the most care is a load edge landing in the same cycle that memory accepts a request. Only the load may move the pointer in that cycle, while the accepted request must still go out with the old address. The bench provokes this by holding `memReqReady` high, waiting for a cycle in which its model predicts a request, and raising `loadCtl` in exactly that cycle. It then expects both `position` and `memReqAddr` to land on the start address in the following cycle. A second coincidence, a response arriving together with a pop, is produced repeatedly by random pops. It is judged by the FIFO level staying unchanged.

// File: rtl/ringFetchPkg.sv
package ringFetchPkg;

  // Per-cycle strobes from the control to the datapath
  typedef struct packed {
    logic loadPtr;   // reload pointer from start address
    logic advPtr;    // request accepted: step or wrap pointer
    logic push;      // write returned line into the FIFO
    logic pop;       // remove head line
    logic flush;     // empty the FIFO
  } fetchStrobe_t;

endpackage

// File: rtl/ringFetchControl.sv
module ringFetchControl
  import ringFetchPkg::*;
#(
  parameter int CNT_W = 4,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanEn,
  input  logic             loadCtl,
  input  logic [CNT_W-1:0] depthM1,
  input  logic [CNT_W-1:0] threshM1,
  input  logic [LVL_W-1:0] level,
  input  logic             memReqReady,
  input  logic             memRspValid,
  input  logic             popReq,
  output logic             memReqValid,
  output logic             reqBusy,
  output fetchStrobe_t     strobe
);

  logic             loadPrev;
  logic             outstanding;
  logic [LVL_W-1:0] thrLines;
  logic             roomOk;
  logic             belowThr;
  logic             accept;
  logic             rspTake;

  // Threshold in lines; level may not exceed it when a refill starts
  always_comb begin
    thrLines = LVL_W'(threshM1) + LVL_W'(1);
    belowThr = (level <= thrLines);
    // level <= depthM1 means one free line remains within the usable depth
    roomOk   = (level <= LVL_W'(depthM1));
  end

  always_comb begin
    memReqValid = chanEn & ~outstanding & roomOk & belowThr;
    accept      = memReqValid & memReqReady;
    rspTake     = memRspValid & outstanding;
  end

  always_comb begin
    strobe         = '0;
    strobe.loadPtr = loadCtl & ~loadPrev;
    strobe.advPtr  = accept;
    strobe.flush   = ~chanEn;
    strobe.push    = rspTake & chanEn;
    strobe.pop     = popReq & (level != '0) & chanEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadPrev    <= 1'b0;
      outstanding <= 1'b0;
    end else begin
      loadPrev <= loadCtl;
      if (accept) begin
        outstanding <= 1'b1;
      end else if (rspTake) begin
        outstanding <= 1'b0;
      end
    end
  end

  assign reqBusy = outstanding;

endmodule

// File: rtl/ringFetchDatapath.sv
module ringFetchDatapath
  import ringFetchPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LINE_W    = 64,
  parameter int MAX_LINES = 16,
  parameter int LVL_W     = $clog2(MAX_LINES + 1),
  parameter int IDX_W     = $clog2(MAX_LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fetchStrobe_t      strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] finishAddr,
  input  logic [LINE_W-1:0] rspData,
  output logic [ADDR_W-1:0] curPtr,
  output logic [LVL_W-1:0]  level,
  output logic [LINE_W-1:0] headData,
  output logic [ADDR_W-1:0] position
);

  localparam int STEP = LINE_W / 8;

  logic [LINE_W-1:0] slot [MAX_LINES];
  logic [IDX_W-1:0]  wrIdx;
  logic [IDX_W-1:0]  rdIdx;
  logic              doPush;
  logic              doPop;

  function automatic logic [IDX_W-1:0] bumpIdx(input logic [IDX_W-1:0] idx);
    if (idx == IDX_W'(MAX_LINES - 1)) begin
      return '0;
    end
    return idx + IDX_W'(1);
  endfunction

  // Read pointer: a load edge has priority over a step or wrap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPtr <= '0;
    end else if (strobe.loadPtr) begin
      curPtr <= startAddr;
    end else if (strobe.advPtr) begin
      if (curPtr == finishAddr) begin
        curPtr <= startAddr;
      end else begin
        curPtr <= curPtr + ADDR_W'(STEP);
      end
    end
  end

  always_comb begin
    doPush = strobe.push & ~strobe.flush & (level != LVL_W'(MAX_LINES));
    doPop  = strobe.pop & ~strobe.flush;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < MAX_LINES; i++) begin
      if (doPush && wrIdx == IDX_W'(i)) begin
        slot[i] <= rspData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      wrIdx <= '0;
      rdIdx <= '0;
      level <= '0;
    end else begin
      if (doPush) wrIdx <= bumpIdx(wrIdx);
      if (doPop)  rdIdx <= bumpIdx(rdIdx);
      case ({doPush, doPop})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end

  assign headData = slot[rdIdx];
  assign position = curPtr - startAddr;

endmodule

// File: rtl/ringLineFetcher.sv
module ringLineFetcher
  import ringFetchPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LINE_W    = 64,
  parameter int MAX_LINES = 16,
  parameter int CNT_W     = $clog2(MAX_LINES),
  parameter int LVL_W     = $clog2(MAX_LINES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chanEn,
  input  logic              loadCtl,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] finishAddr,
  input  logic [CNT_W-1:0]  depthM1,
  input  logic [CNT_W-1:0]  threshM1,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memReqReady,
  input  logic              memRspValid,
  input  logic [LINE_W-1:0] memRspData,
  input  logic              popReq,
  output logic [LINE_W-1:0] popData,
  output logic [LVL_W-1:0]  fifoLevel,
  output logic [ADDR_W-1:0] position
);

  fetchStrobe_t ctlStrobe;
  logic         reqBusy;

  ringFetchControl #(
    .CNT_W(CNT_W),
    .LVL_W(LVL_W)
  ) ctrlU (
    .clk        (clk),
    .rstN       (rstN),
    .chanEn     (chanEn),
    .loadCtl    (loadCtl),
    .depthM1    (depthM1),
    .threshM1   (threshM1),
    .level      (fifoLevel),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .popReq     (popReq),
    .memReqValid(memReqValid),
    .reqBusy    (reqBusy),
    .strobe     (ctlStrobe)
  );

  ringFetchDatapath #(
    .ADDR_W   (ADDR_W),
    .LINE_W   (LINE_W),
    .MAX_LINES(MAX_LINES),
    .LVL_W    (LVL_W),
    .IDX_W    (CNT_W)
  ) dpU (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (ctlStrobe),
    .startAddr (startAddr),
    .finishAddr(finishAddr),
    .rspData   (memRspData),
    .curPtr    (memReqAddr),
    .level     (fifoLevel),
    .headData  (popData),
    .position  (position)
  );

endmodule

// File: rtl/ringFetchChecker.sv
module ringFetchChecker
  import ringFetchPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LINE_W    = 64,
  parameter int MAX_LINES = 16,
  parameter int LVL_W     = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              chanEn,
  input logic              popReq,
  input logic [ADDR_W-1:0] startAddr,
  input logic [ADDR_W-1:0] finishAddr,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRspValid,
  input logic [LVL_W-1:0]  fifoLevel,
  input logic [ADDR_W-1:0] position,
  input fetchStrobe_t      ctlStrobe,
  input logic              reqBusy
);

  localparam int STEP = LINE_W / 8;

  // R2: a plain acceptance moves the offset by one line
  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady && !ctlStrobe.loadPtr && memReqAddr != finishAddr)
    |=> (startAddr != $past(startAddr)) || (position == $past(position) + ADDR_W'(STEP)));

  // R3: accepting the finish line returns to the start
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady && !ctlStrobe.loadPtr && memReqAddr == finishAddr)
    |=> (startAddr != $past(startAddr)) || (position == '0));

  // R6: a load edge zeroes the offset
  a_r6_load: assert property (@(posedge clk) disable iff (!rstN)
    ctlStrobe.loadPtr |=> (startAddr != $past(startAddr)) || (position == '0));

  // R5: no second request straight after an acceptance
  a_r5_single: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady) |=> !memReqValid);

  // R5: nothing requested while one is in flight
  a_r5_busy: assert property (@(posedge clk) disable iff (!rstN)
    reqBusy |-> !memReqValid);

  // R8: idle channel raises no request
  a_r8_idle: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |-> !memReqValid);

  // R8: idle channel empties the FIFO
  a_r8_flush: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> fifoLevel == '0);

  // R9: popping an empty FIFO leaves it empty when nothing arrives
  a_r9_empty_pop: assert property (@(posedge clk) disable iff (!rstN)
    (chanEn && fifoLevel == '0 && popReq && !memRspValid) |=> fifoLevel == '0);

  // R10: level never exceeds storage
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= LVL_W'(MAX_LINES));

endmodule

bind ringLineFetcher ringFetchChecker #(
  .ADDR_W   (ADDR_W),
  .LINE_W   (LINE_W),
  .MAX_LINES(MAX_LINES),
  .LVL_W    (LVL_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .chanEn     (chanEn),
  .popReq     (popReq),
  .startAddr  (startAddr),
  .finishAddr (finishAddr),
  .memReqValid(memReqValid),
  .memReqReady(memReqReady),
  .memReqAddr (memReqAddr),
  .memRspValid(memRspValid),
  .fifoLevel  (fifoLevel),
  .position   (position),
  .ctlStrobe  (ctlStrobe),
  .reqBusy    (reqBusy)
);

// File: tb/ringLineFetcher_tb_top.sv
module ringLineFetcher_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        chanEn, loadCtl, memReqReady, memRspValid, popReq;
  logic [31:0] startAddr, finishAddr;
  logic [3:0]  depthM1, threshM1;
  logic [63:0] memRspData;
  logic        memReqValid;
  logic [31:0] memReqAddr, position;
  logic [63:0] popData;
  logic [4:0]  fifoLevel;

  ringLineFetcher dut_i (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .loadCtl(loadCtl),
    .startAddr(startAddr), .finishAddr(finishAddr),
    .depthM1(depthM1), .threshM1(threshM1),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .popReq(popReq), .popData(popData), .fifoLevel(fifoLevel), .position(position)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Reference model state
  logic [63:0] q[$];
  logic [31:0] mPtr;
  bit          mOut, mLoadPrev;
  bit          lastAcc, lastTake;
  int          wrapSeen = 0;

  // Memory responder state
  bit          memAuto = 1;
  bit          pendV = 0;
  logic [31:0] pendAddr;
  int          lat;

  function automatic logic [63:0] lineOf(input logic [31:0] a);
    return {a, a ^ 32'hA5A5_5A5A};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit mReqV();
    return chanEn && !mOut && (q.size() <= int'(threshM1) + 1) && (q.size() <= int'(depthM1));
  endfunction

  task automatic modelStep();
    bit acc, rise, take, popOk;
    logic [31:0] old;
    acc   = mReqV() && memReqReady;
    rise  = loadCtl && !mLoadPrev;
    take  = memRspValid && mOut;
    popOk = popReq && (q.size() > 0);
    old   = mPtr;
    if (!chanEn) q.delete();
    else begin
      if (popOk) void'(q.pop_front());
      if (take) q.push_back(memRspData);
    end
    if (rise) mPtr = startAddr;
    else if (acc) begin
      if (mPtr == finishAddr) begin mPtr = startAddr; wrapSeen++; end
      else mPtr = mPtr + 32'd8;
    end
    if (acc) mOut = 1; else if (take) mOut = 0;
    mLoadPrev = loadCtl;
    if (take) pendV = 0;
    else if (pendV && lat > 0) lat--;
    if (acc) begin pendV = 1; pendAddr = old; lat = $urandom_range(0, 3); end
    lastAcc  = acc;
    lastTake = take;
  endtask

  // One clock: called just after a falling edge with inputs set
  task automatic cycle();
    logic [31:0] expPos;
    if (memAuto) begin
      memRspValid = pendV && (lat == 0);
      memRspData  = lineOf(pendAddr);
    end
    #1;
    expPos = mPtr - startAddr;
    chk("R4 request valid", {63'd0, memReqValid}, {63'd0, mReqV()});
    chk("R2 request address", {32'd0, memReqAddr}, {32'd0, mPtr});
    chk("R10 fifo level", {59'd0, fifoLevel}, 64'(q.size()));
    if (q.size() > 0) chk("R9 head data", popData, q[0]);
    chk("R7 position", {32'd0, position}, {32'd0, expPos});
    modelStep();
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4:0] lvlBefore;
    rstN = 0; chanEn = 0; loadCtl = 0; memReqReady = 0; memRspValid = 0; popReq = 0;
    memRspData = '0; startAddr = 32'h1000; finishAddr = 32'h1038;
    depthM1 = 4'd7; threshM1 = 4'd3;
    mPtr = 0; mOut = 0; mLoadPrev = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset level", {59'd0, fifoLevel}, 64'd0);
    chk("R1 reset no request", {63'd0, memReqValid}, 64'd0);
    chk("R1 reset pointer", {32'd0, memReqAddr}, 64'd0);
    @(negedge clk);
    rstN = 1;
    cycle();
    chk("R1 idle after reset", {63'd0, memReqValid}, 64'd0);

    // Load then stream with random ready and pops (R2, R3, R4, R10)
    loadCtl = 1; cycle();
    loadCtl = 0; chanEn = 1;
    for (int i = 0; i < 400; i++) begin
      memReqReady = ($urandom_range(0, 3) != 0);
      popReq      = ($urandom_range(0, 9) < 4);
      cycle();
    end
    chk("R3 wrap happened", {63'd0, wrapSeen > 0}, 64'd1);

    // Hold load high: only the first edge reloads (R6)
    loadCtl = 1;
    for (int i = 0; i < 60; i++) begin
      memReqReady = 1; popReq = ($urandom_range(0, 1) == 1);
      cycle();
    end
    #1;
    chk("R6 held load no reload", {32'd0, position}, {32'd0, mPtr - startAddr});
    chk("R6 pointer moved after edge", {63'd0, position != 0}, {63'd0, mPtr != startAddr});
    loadCtl = 0; popReq = 1; memReqReady = 1;
    cycle();

    // Load edge coinciding with an accepted request (R6)
    begin
      int guard = 0;
      popReq = 1; memReqReady = 1;
      while (!mReqV() && guard < 50) begin cycle(); guard++; end
      loadCtl = 1;
      cycle();
      chk("R6 same-cycle accept took request", {63'd0, lastAcc}, 64'd1);
      #1;
      chk("R6 load wins pointer", {32'd0, position}, 64'd0);
      chk("R6 pointer at start", {32'd0, memReqAddr}, {32'd0, startAddr});
      loadCtl = 0;
    end

    // Single outstanding and spurious responses (R5)
    memAuto = 0; memRspValid = 0; memReqReady = 1; popReq = 1;
    begin
      int guard = 0;
      while (!mOut && guard < 50) begin cycle(); guard++; end
    end
    popReq = 0;
    for (int i = 0; i < 4; i++) begin
      cycle();
      #1;
      chk("R5 no second request", {63'd0, memReqValid}, 64'd0);
    end
    memRspValid = 1; memRspData = lineOf(pendAddr);
    cycle();
    memReqReady = 0; memRspValid = 1; memRspData = 64'hDEAD_BEEF_0000_0001;
    lvlBefore = fifoLevel;
    cycle();
    #1;
    chk("R5 spurious response ignored", {59'd0, fifoLevel}, {59'd0, lvlBefore});
    memRspValid = 0;
    cycle();

    // Disable with a response in flight (R8)
    memReqReady = 1; popReq = 1;
    begin
      int guard = 0;
      while (!mOut && guard < 50) begin cycle(); guard++; end
    end
    memReqReady = 0; popReq = 0;
    chanEn = 0; memRspValid = 1; memRspData = lineOf(pendAddr);
    cycle();
    memRspValid = 0;
    cycle();
    #1;
    chk("R8 flushed while disabled", {59'd0, fifoLevel}, 64'd0);
    chk("R8 no request while disabled", {63'd0, memReqValid}, 64'd0);
    chanEn = 1; memReqReady = 1;
    #1;
    chk("R8 outstanding cleared by discarded response", {63'd0, memReqValid}, 64'd1);
    memAuto = 1;
    cycle();

    // Drain and pop while empty (R9)
    memReqReady = 0; popReq = 1;
    for (int i = 0; i < 30; i++) cycle();
    #1;
    chk("R9 drained", {59'd0, fifoLevel}, 64'd0);
    cycle();
    #1;
    chk("R9 empty pop ignored", {59'd0, fifoLevel}, 64'd0);

    // Ring near the top of the address space (R7, R3)
    popReq = 0;
    startAddr = 32'hFFFF_FFF0; finishAddr = 32'hFFFF_FFF8;
    depthM1 = 4'd15; threshM1 = 4'd7;
    loadCtl = 1; cycle(); loadCtl = 0;
    for (int i = 0; i < 120; i++) begin
      memReqReady = ($urandom_range(0, 2) != 0);
      popReq      = ($urandom_range(0, 1) == 1);
      cycle();
    end
    #1;
    chk("R7 modular position", {32'd0, position}, {32'd0, mPtr - startAddr});

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule